// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a serial-bus slave that gives a host access to a bank of sixteen 8-bit configuration registers. The bank contents are also driven in parallel onto a wide output bus, so neighbouring logic can use the settings directly. SCL and SDA come in as plain inputs. The block resamples both on its own system clock, which must run at least eight times faster than SCL. It pulls SDA low through a single drive-low output that the pad turns into an open-drain driver.

Every transfer uses indexed block framing. In a write, the host addresses the slave for writing, then sends a starting index, then a byte count, then that many data bytes. The data bytes land in consecutive registers. A read starts with a write-addressed phase that carries only the index. The host then issues a repeated start with the read address. The slave answers with the value held in a dedicated count location, followed by consecutive register bytes, until the host refuses a byte.

Top module: `smb_idx_regbank`

## Requirements
- R1: Coming out of reset, every register i holds (16*i) mod 256, except location 8, which holds 0x04. The slave leaves SDA released.
- R2: The slave acknowledges the address bytes 0xD2 (write) and 0xD3 (read) and no others. After any other address byte it does not acknowledge, ignores the rest of the transaction and changes no register.
- R3: In a write, the slave acknowledges the index byte and the count byte. It stores data byte k (counting from 0) at location index+k and acknowledges each data byte. The new value shows on the parallel output bus before the next byte starts.
- R4: After the number of data bytes given by the count has been received, any further data byte is not acknowledged and is not stored. With a count of 0, the first data byte is already refused.
- R5: Only the low 4 bits of the index byte select the location. Consecutive accesses wrap from location 15 to location 0.
- R6: After a repeated start with 0xD3, the slave sends the content of location 8 first. It then sends the registers from the last written index onward, one location per byte, MSB first. It stops driving after a byte the host refuses, and SDA is released once the stop condition has been seen.
- R7: Writing location 8 changes the count that later reads report.
- R8: A stop or start condition in the middle of a byte aborts the byte. Registers committed earlier in that transaction keep their new values, and the partial byte is not stored. A start seen mid-byte begins a fresh address phase that works normally.
- R9: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low_o | output | 1 | High when the slave pulls SDA low |
| regs_o | output | 128 | All registers in parallel, location i at bits [8*i+7:8*i] |

## Verification
The bench aims at the edges of the counted framing. It sends one byte beyond the count and sends a zero count; a slave that stored or acknowledged such bytes would corrupt the register after the block. It runs index bytes with high bits set and transfers that cross location 15; a wrong mask or wrap would write to, or read from, the wrong place. It rewrites the count location before reading, and it aborts a transfer with stop and with start partway through a byte. Mishandling either abort shows up as a half byte committed, a lost earlier byte, or a slave that ignores the next address. A monitor watches for any SDA change from the slave while SCL is high, which the host would take for a false start or stop.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RECV,
    S_ACK,
    S_SEND,
    S_HACK
  } smb_st_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_INDEX,
    K_COUNT,
    K_DATA
  } smb_kind_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [2:0] scl_pipe;
  logic [2:0] sda_pipe;

  // Two flops for metastability, a third to find edges. Idle bus is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= 3'b111;
      sda_pipe <= 3'b111;
    end else begin
      scl_pipe <= {scl_pipe[1:0], scl_i};
      sda_pipe <= {sda_pipe[1:0], sda_i};
    end
  end

  assign scl_s     = scl_pipe[1];
  assign sda_s     = sda_pipe[1];
  assign scl_rise  =  scl_pipe[1] & ~scl_pipe[2];
  assign scl_fall  = ~scl_pipe[1] &  scl_pipe[2];
  assign start_det =  scl_pipe[1] &  scl_pipe[2] & ~sda_pipe[1] &  sda_pipe[2];
  assign stop_det  =  scl_pipe[1] &  scl_pipe[2] &  sda_pipe[1] & ~sda_pipe[2];

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int          NUM_REGS  = 16,
  parameter int          AW        = 4,
  parameter int          COUNT_IDX = 8,
  parameter logic [7:0]  COUNT_DEF = 8'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [7:0]            wdata,
  input  logic [AW-1:0]         rd_idx,
  output logic [7:0]            rd_data,
  output logic [7:0]            cnt_val,
  output logic [NUM_REGS*8-1:0] regs_o
);

  logic [7:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_loc
    localparam logic [7:0] DEF = (g == COUNT_IDX) ? COUNT_DEF : 8'((g * 16) % 256);
    logic hit;
    assign hit = we && (waddr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[g] <= DEF;
      else if (hit) mem[g] <= wdata;
    end

    assign regs_o[g*8 +: 8] = mem[g];
  end

  assign rd_data = mem[rd_idx];
  assign cnt_val = mem[COUNT_IDX];

endmodule

// File: rtl/smb_xact_fsm.sv
module smb_xact_fsm
  import smb_idx_pkg::*;
#(
  parameter int         AW      = 4,
  parameter logic [7:0] WR_ADDR = 8'hD2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    cnt_val,
  output logic [AW-1:0] rd_idx,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output logic          sda_drive_low,
  output smb_st_e       st
);

  localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

  smb_st_e   st_q,   st_d;
  smb_kind_e kind_q, kind_d;
  logic [2:0]    cnt_q,    cnt_d;
  logic          done_q,   done_d;
  logic [7:0]    sh_q,     sh_d;
  logic [7:0]    tx_q,     tx_d;
  logic [AW-1:0] ptr_q,    ptr_d;
  logic [7:0]    remain_q, remain_d;
  logic          drv_q,    drv_d;
  logic          send_q,   send_d;
  logic          more_q,   more_d;

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    cnt_d    = cnt_q;
    done_d   = done_q;
    sh_d     = sh_q;
    tx_d     = tx_q;
    ptr_d    = ptr_q;
    remain_d = remain_q;
    drv_d    = drv_q;
    send_d   = send_q;
    more_d   = more_q;
    we       = 1'b0;

    if (stop_det) begin
      st_d  = S_IDLE;
      drv_d = 1'b0;
    end else if (start_det) begin
      st_d   = S_RECV;
      kind_d = K_ADDR;
      cnt_d  = 3'd0;
      done_d = 1'b0;
      drv_d  = 1'b0;
      send_d = 1'b0;
    end else begin
      unique case (st_q)
        S_RECV: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) done_d = 1'b1;
          end else if (scl_fall && done_q) begin
            done_d = 1'b0;
            st_d   = S_ACK;
            unique case (kind_q)
              K_ADDR: begin
                if (sh_q == WR_ADDR) begin
                  drv_d  = 1'b1;
                  kind_d = K_INDEX;
                  send_d = 1'b0;
                end else if (sh_q == RD_ADDR) begin
                  drv_d  = 1'b1;
                  send_d = 1'b1;
                end else begin
                  st_d = S_IDLE;
                end
              end
              K_INDEX: begin
                ptr_d  = sh_q[AW-1:0];
                drv_d  = 1'b1;
                kind_d = K_COUNT;
              end
              K_COUNT: begin
                remain_d = sh_q;
                drv_d    = 1'b1;
                kind_d   = K_DATA;
              end
              default: begin
                if (remain_q != 8'd0) begin
                  we       = 1'b1;
                  ptr_d    = ptr_q + AW'(1);
                  remain_d = remain_q - 8'd1;
                  drv_d    = 1'b1;
                end else begin
                  st_d = S_IDLE;
                end
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt_d = 3'd0;
            if (send_q) begin
              send_d = 1'b0;
              tx_d   = cnt_val;
              drv_d  = ~cnt_val[7];
              st_d   = S_SEND;
            end else begin
              drv_d = 1'b0;
              st_d  = S_RECV;
            end
          end
        end
        S_SEND: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              drv_d = 1'b0;
              st_d  = S_HACK;
            end else begin
              tx_d  = {tx_q[6:0], 1'b0};
              drv_d = ~tx_q[6];
              cnt_d = cnt_q + 3'd1;
            end
          end
        end
        S_HACK: begin
          if (scl_rise) begin
            more_d = ~sda_s;
          end else if (scl_fall) begin
            if (more_q) begin
              tx_d  = rd_data;
              drv_d = ~rd_data[7];
              ptr_d = ptr_q + AW'(1);
              cnt_d = 3'd0;
              st_d  = S_SEND;
            end else begin
              st_d = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      kind_q   <= K_ADDR;
      cnt_q    <= 3'd0;
      done_q   <= 1'b0;
      sh_q     <= 8'd0;
      tx_q     <= 8'd0;
      ptr_q    <= '0;
      remain_q <= 8'd0;
      drv_q    <= 1'b0;
      send_q   <= 1'b0;
      more_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      kind_q   <= kind_d;
      cnt_q    <= cnt_d;
      done_q   <= done_d;
      sh_q     <= sh_d;
      tx_q     <= tx_d;
      ptr_q    <= ptr_d;
      remain_q <= remain_d;
      drv_q    <= drv_d;
      send_q   <= send_d;
      more_q   <= more_d;
    end
  end

  assign rd_idx        = ptr_q;
  assign waddr         = ptr_q;
  assign wdata         = sh_q;
  assign sda_drive_low = drv_q;
  assign st            = st_q;

endmodule

// File: rtl/smb_idx_regbank.sv
module smb_idx_regbank
  import smb_idx_pkg::*;
#(
  parameter int         NUM_REGS  = 16,
  parameter logic [7:0] WR_ADDR   = 8'hD2,
  parameter int         COUNT_IDX = 8,
  parameter logic [7:0] COUNT_DEF = 8'h04
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int AW = $clog2(NUM_REGS);

  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          reg_we;
  logic [AW-1:0] reg_waddr, rd_idx;
  logic [7:0]    reg_wdata, rd_data, cnt_val;
  smb_st_e       fsm_st;

  smb_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_xact_fsm #(
    .AW      (AW),
    .WR_ADDR (WR_ADDR)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .sda_s         (sda_s),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .rd_data       (rd_data),
    .cnt_val       (cnt_val),
    .rd_idx        (rd_idx),
    .we            (reg_we),
    .waddr         (reg_waddr),
    .wdata         (reg_wdata),
    .sda_drive_low (sda_drive_low_o),
    .st            (fsm_st)
  );

  smb_reg_bank #(
    .NUM_REGS  (NUM_REGS),
    .AW        (AW),
    .COUNT_IDX (COUNT_IDX),
    .COUNT_DEF (COUNT_DEF)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .we      (reg_we),
    .waddr   (reg_waddr),
    .wdata   (reg_wdata),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .cnt_val (cnt_val),
    .regs_o  (regs_o)
  );

endmodule

// File: rtl/smb_idx_regbank_chk.sv
module smb_idx_regbank_chk
  import smb_idx_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input smb_st_e st,
  input logic    start_det,
  input logic    stop_det,
  input logic    scl_s,
  input logic    reg_we,
  input logic    sda_drive_low
);

  // R1 / R6: whenever the slave is idle, SDA is released
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_drive_low);

  // R9: the slave only starts pulling SDA while SCL is low
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_s);

  // R3: a committed register write is always acknowledged
  a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> sda_drive_low);

  // R8: stop returns to idle
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE));

  // R8: start opens a fresh address phase
  a_r8_start_recv: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_RECV));

endmodule

bind smb_idx_regbank smb_idx_regbank_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st            (fsm_st),
  .start_det     (start_det),
  .stop_det      (stop_det),
  .scl_s         (scl_s),
  .reg_we        (reg_we),
  .sda_drive_low (sda_drive_low_o)
);

// File: tb/tb_smb_idx_regbank.sv
module tb_smb_idx_regbank;

  localparam int Q    = 5;
  localparam int NR   = 16;
  localparam int CIDX = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            host_scl;
  logic            host_low;
  logic            dut_low;
  logic            sda_line;
  logic [NR*8-1:0] regs;

  assign sda_line = ~(host_low | dut_low);

  smb_idx_regbank dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_i           (host_scl),
    .sda_i           (sda_line),
    .sda_drive_low_o (dut_low),
    .regs_o          (regs)
  );

  int         total = 0;
  int         bad   = 0;
  int         r9_bad = 0;
  bit         finished = 0;
  logic [7:0] model [NR];
  logic [7:0] wbuf  [8];
  logic       prev_low = 1'b0;

  function automatic logic [7:0] def_val(int i);
    return (i == CIDX) ? 8'h04 : 8'((i * 16) % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R9 monitor: slave drive must not change while SCL is high
  always @(posedge clk) begin
    #1;
    if (rst_n && (dut_low != prev_low) && host_scl) r9_bad++;
    prev_low = dut_low;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 1'b0; wq(Q);
    host_scl = 1'b1; wq(Q);
    host_low = 1'b1; wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; wq(Q);
    host_scl = 1'b1; wq(Q);
    host_low = 1'b0; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    host_low = ~b;   wq(Q);
    host_scl = 1'b1; wq(2*Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    host_low = 1'b0; wq(Q);
    host_scl = 1'b1; wq(Q);
    ack = (sda_line == 1'b0);
    wq(Q);
    host_scl = 1'b0; wq(Q);
  endtask

  task automatic read_byte(input bit ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      host_scl = 1'b1; wq(Q);
      b[i] = sda_line;
      wq(Q);
      host_scl = 1'b0;
    end
    host_low = ack; wq(Q);
    host_scl = 1'b1; wq(2*Q);
    host_scl = 1'b0; wq(Q);
    host_low = 1'b0;
  endtask

  task automatic check_bank(input string req);
    int first = -1;
    for (int i = 0; i < NR; i++)
      if (first < 0 && regs[i*8 +: 8] !== model[i]) first = i;
    if (first < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(regs[first*8 +: 8]), int'(model[first]));
  endtask

  // Write transaction with cnt as the count byte and nsend data bytes from wbuf
  task automatic wr_xact(input logic [7:0] idx, input int cnt, input int nsend, input string req);
    bit a;
    bus_start();
    write_byte(8'hD2, a); chk(a, "R2 write address ack", a, 1);
    write_byte(idx, a);   chk(a, "R3 index ack", a, 1);
    write_byte(8'(cnt), a); chk(a, "R3 count ack", a, 1);
    for (int k = 0; k < nsend; k++) begin
      write_byte(wbuf[k], a);
      if (k < cnt) begin
        chk(a == 1'b1, "R3 data ack", a, 1);
        model[(int'(idx[3:0]) + k) % NR] = wbuf[k];
      end else begin
        chk(a == 1'b0, "R4 surplus byte nack", a, 0);
      end
      if (!a) break;
    end
    bus_stop();
    check_bank(req);
  endtask

  task automatic rd_xact(input logic [7:0] idx, input int n, input string req);
    bit a;
    logic [7:0] b;
    bus_start();
    write_byte(8'hD2, a); chk(a, "R6 index phase address ack", a, 1);
    write_byte(idx, a);   chk(a, "R6 index ack", a, 1);
    bus_start();
    write_byte(8'hD3, a); chk(a, "R2 read address ack", a, 1);
    read_byte(n > 0, b);
    chk(b == model[CIDX], "R7 count byte", b, model[CIDX]);
    for (int k = 0; k < n; k++) begin
      read_byte(k < n - 1, b);
      chk(b == model[(int'(idx[3:0]) + k) % NR], req, b, model[(int'(idx[3:0]) + k) % NR]);
    end
    bus_stop();
    chk(dut_low == 1'b0, "R6 released after read", dut_low, 0);
  endtask

  task automatic bad_addr(input logic [7:0] adr);
    bit a;
    bus_start();
    write_byte(adr, a); chk(a == 1'b0, "R2 foreign address nack", a, 0);
    write_byte(8'h01, a);
    write_byte(8'h02, a);
    write_byte(8'hEE, a);
    bus_stop();
    check_bank("R2 foreign address ignored");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    int n;
    logic [7:0] idx;
    host_scl = 1'b1;
    host_low = 1'b0;
    rst_n    = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = def_val(i);
    wq(5);
    rst_n = 1'b1;
    wq(10);

    // R1 reset state
    check_bank("R1 reset defaults");
    chk(dut_low == 1'b0, "R1 sda released", dut_low, 0);

    // R3 basic write
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    wr_xact(8'h03, 2, 2, "R3 consecutive store");

    // R2 foreign addresses
    bad_addr(8'hA0);
    bad_addr(8'hD4);

    // R5 wrap past 15, high index bits ignored
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_xact(8'h0E, 4, 4, "R5 wrap write");
    wbuf[0] = 8'h9C;
    wr_xact(8'h25, 1, 1, "R5 index masked");

    // R4 surplus byte and zero count
    wbuf[0] = 8'h61; wbuf[1] = 8'h62;
    wr_xact(8'h0A, 1, 2, "R4 surplus not stored");
    wbuf[0] = 8'h7E;
    wr_xact(8'h09, 0, 1, "R4 zero count");

    // R7 program count, then R6 read across the wrap
    wbuf[0] = 8'h03;
    wr_xact(8'h08, 1, 1, "R7 count written");
    rd_xact(8'h0E, 3, "R6 read data");
    rd_xact(8'h02, 0, "R6 count only");

    // R8 stop mid-byte
    bus_start();
    write_byte(8'hD2, a); write_byte(8'h06, a); write_byte(8'h03, a);
    write_byte(8'h3C, a); chk(a, "R8 first byte ack", a, 1);
    model[6] = 8'h3C;
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    check_bank("R8 stop mid-byte");

    // R8 start mid-byte, fresh transaction follows
    bus_start();
    write_byte(8'hD2, a); write_byte(8'h0C, a); write_byte(8'h02, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    write_byte(8'hD2, a); chk(a, "R8 address after restart", a, 1);
    write_byte(8'h0C, a); write_byte(8'h01, a);
    write_byte(8'h77, a); chk(a, "R8 data after restart", a, 1);
    model[12] = 8'h77;
    bus_stop();
    check_bank("R8 start mid-byte");

    // Random mix
    void'($urandom(32'd7321));
    for (int t = 0; t < 24; t++) begin
      if (($urandom % 3) != 0) begin
        int c, s;
        idx = 8'($urandom % 32);
        c = int'($urandom % 5);
        s = c + int'($urandom % 2);
        for (int k = 0; k < 8; k++) wbuf[k] = 8'($urandom);
        wr_xact(idx, c, s, "R3 random write");
      end else begin
        idx = 8'($urandom % 32);
        n = (model[CIDX] > 8'd6) ? 6 : int'(model[CIDX]);
        rd_xact(idx, n, "R6 random read");
      end
    end

    chk(r9_bad == 0, "R9 sda stable while scl high", r9_bad, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule